// File: doc/BRIEF.md
# Phase-Error Supply Trim Controller

This block is the fast inner loop of a per-island supply regulator. A delay-line phase comparator tells it whether a replica of the critical path is slower than one clock period (raise), faster (lower) or aligned (lock). From these indications the block steps a saturating 5-bit trim register. The register drives a bank of switch segments reserved for this loop, which cancels the supply droop that follows changes in circuit activity. The trim range has 25 settings, 0 to 24. A higher value switches on more segments and lowers the series resistance. After each step the loop waits a few cycles so that the supply can settle.

The block also arbitrates between itself and the slower average-supply loop, which reprograms its own segments on request. A slow-loop request is granted for one cycle. It takes priority over a trim step on the same edge and starts the settle interval again, so the two loops never update the switch in the same cycle. The segment decoder turns the trim value into a thermometer-coded enable word, one bit per segment.

Top module: `supply_trim_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `trim_val` is 12, `trim_gnt` and `slow_gnt` are 0, and `seg_word` has exactly bits 0 to 11 set.
- R2: With `ph_up`=1, `ph_dn`=0, `ph_lock`=0, `en`=1, `slow_req`=0, the settle counter expired and `trim_val` below 24, the next edge increments `trim_val` by one and raises `trim_gnt` for that cycle.
- R3: Under the same conditions with `ph_dn`=1 and `ph_up`=0, and `trim_val` above 0, the next edge decrements `trim_val` by one and raises `trim_gnt`.
- R4: When `ph_lock`=1 (whatever `ph_up` and `ph_dn` are), when `ph_up` and `ph_dn` are both 1, or when both are 0, `trim_val` holds and `trim_gnt` stays 0.
- R5: Two trim steps are at least 4 cycles apart. With a raise held steadily, the steps land exactly every 4 edges.
- R6: `trim_val` never goes above 24 or below 0. A raise at 24 or a lower at 0 changes nothing and gives no `trim_gnt`.
- R7: While `en` is 0 no trim step is taken and `trim_gnt` stays 0.
- R8: Each edge that samples `slow_req`=1 gives `slow_gnt`=1 for the following cycle. No trim step is taken on that edge.
- R9: After an edge that grants the slow loop, the next trim step can come no earlier than 4 edges later.
- R10: `trim_gnt` and `slow_gnt` are never high in the same cycle.
- R11: `seg_word` always has bits 0 to `trim_val`-1 set and all other bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the on-chip clock generator |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables trim steps |
| ph_up | input | 1 | Replica delay longer than one period: raise supply |
| ph_dn | input | 1 | Replica delay shorter than one period: lower supply |
| ph_lock | input | 1 | Reference and delayed clock aligned: hold |
| slow_req | input | 1 | Update request from the average-supply loop |
| trim_val | output | 5 | Trim register value, 0 to 24 |
| trim_gnt | output | 1 | High in the cycle after a trim step is applied |
| slow_gnt | output | 1 | One-cycle grant to the average-supply loop |
| seg_word | output | 24 | Thermometer-coded enables for the trim segments |

## Verification
The bench holds a raise steady and checks that steps land exactly four edges apart. A design that counted the settle interval one short or one long would step off that beat. It sends conflicting indications (up together with down, and up together with lock) and a raise while disabled. A design that let any of these through would move the trim. It drives the register against both ends of the range, where a design with a wrong bound would wrap or issue a grant for a step that was never taken. It raises a slow-loop request alongside a pending raise, and it checks both that the trim step yields that edge and that the settle interval starts again. A design that got this wrong would grant both loops in the same cycle or step early.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    TRIM_HOLD  = 2'd0,
    TRIM_RAISE = 2'd1,
    TRIM_LOWER = 2'd2
  } trim_dir_e;
endpackage

// File: rtl/trim_phase_classify.sv
module trim_phase_classify
  import trim_pkg::*;
(
  input  logic      ph_up,
  input  logic      ph_dn,
  input  logic      ph_lock,
  output trim_dir_e dir
);
  // Lock wins; conflicting up/dn is treated as lock.
  always_comb begin
    if (ph_lock || (ph_up == ph_dn)) dir = TRIM_HOLD;
    else if (ph_up)                  dir = TRIM_RAISE;
    else                             dir = TRIM_LOWER;
  end
endmodule

// File: rtl/trim_arbiter.sv
module trim_arbiter #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic slow_req,
  input  logic want_step,
  output logic step_ok,
  output logic slow_gnt,
  output logic trim_gnt
);
  localparam int HW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC - 1);

  logic [HW-1:0] hold_cnt;
  logic          settled;

  assign settled = (hold_cnt == '0);
  // The slow loop has priority; trim only moves when settled and enabled.
  assign step_ok = en && !slow_req && settled && want_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      slow_gnt <= 1'b0;
      trim_gnt <= 1'b0;
    end else begin
      slow_gnt <= slow_req;
      trim_gnt <= step_ok;
      if (slow_req || step_ok) hold_cnt <= HOLD_LOAD;
      else if (!settled)       hold_cnt <= hold_cnt - 1'b1;
    end
  end

  p_mutex_r10: assert property (@(posedge clk) disable iff (rst)
    !(slow_gnt && trim_gnt));

  p_slow_grant_r8: assert property (@(posedge clk) disable iff (rst)
    slow_req |=> (slow_gnt && !trim_gnt));

  p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (rst)
    trim_gnt |=> !trim_gnt);

  p_after_slow_r9: assert property (@(posedge clk) disable iff (rst)
    slow_gnt |=> !trim_gnt);
endmodule

// File: rtl/trim_accum.sv
module trim_accum
  import trim_pkg::*;
#(
  parameter int TW       = 5,
  parameter int TRIM_MAX = 24,
  parameter int TRIM_RST = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  trim_dir_e     dir,
  input  logic          step_ok,
  output logic          want_step,
  output logic [TW-1:0] trim_val,
  output logic [TW-1:0] trim_next
);
  localparam logic [TW-1:0] TOP  = TW'(TRIM_MAX);
  localparam logic [TW-1:0] INIT = TW'(TRIM_RST);

  logic at_top, at_bot;
  assign at_top = (trim_val >= TOP);
  assign at_bot = (trim_val == '0);

  always_comb begin
    unique case (dir)
      TRIM_RAISE: want_step = !at_top;
      TRIM_LOWER: want_step = !at_bot;
      default:    want_step = 1'b0;
    endcase
  end

  always_comb begin
    trim_next = trim_val;
    if (step_ok) begin
      if (dir == TRIM_RAISE)      trim_next = trim_val + 1'b1;
      else if (dir == TRIM_LOWER) trim_next = trim_val - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trim_val <= INIT;
    else     trim_val <= trim_next;
  end

  p_range_r6: assert property (@(posedge clk) disable iff (rst)
    trim_val <= TOP);

  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
    (trim_val == $past(trim_val)) || (trim_val == $past(trim_val) + 1'b1) ||
    (trim_val == $past(trim_val) - 1'b1));
endmodule

// File: rtl/trim_seg_decoder.sv
module trim_seg_decoder #(
  parameter int TW       = 5,
  parameter int TRIM_MAX = 24,
  parameter int TRIM_RST = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TW-1:0]       trim_next,
  output logic [TRIM_MAX-1:0] seg_word
);
  for (genvar i = 0; i < TRIM_MAX; i++) begin : g_seg
    localparam logic RST_BIT = (i < TRIM_RST);
    always_ff @(posedge clk) begin
      if (rst) seg_word[i] <= RST_BIT;
      else     seg_word[i] <= (trim_next > TW'(i));
    end
  end
endmodule

// File: rtl/supply_trim_ctrl.sv
module supply_trim_ctrl
  import trim_pkg::*;
#(
  parameter int TW       = 5,
  parameter int TRIM_MAX = 24,
  parameter int TRIM_RST = 12,
  parameter int HOLD_CYC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                ph_up,
  input  logic                ph_dn,
  input  logic                ph_lock,
  input  logic                slow_req,
  output logic [TW-1:0]       trim_val,
  output logic                trim_gnt,
  output logic                slow_gnt,
  output logic [TRIM_MAX-1:0] seg_word
);
  trim_dir_e     dir;
  logic          want_step, step_ok;
  logic [TW-1:0] trim_next;

  trim_phase_classify u_cls (
    .ph_up(ph_up), .ph_dn(ph_dn), .ph_lock(ph_lock), .dir(dir)
  );

  trim_arbiter #(.HOLD_CYC(HOLD_CYC)) u_arb (
    .clk(clk), .rst(rst), .en(en), .slow_req(slow_req),
    .want_step(want_step), .step_ok(step_ok),
    .slow_gnt(slow_gnt), .trim_gnt(trim_gnt)
  );

  trim_accum #(.TW(TW), .TRIM_MAX(TRIM_MAX), .TRIM_RST(TRIM_RST)) u_acc (
    .clk(clk), .rst(rst), .dir(dir), .step_ok(step_ok),
    .want_step(want_step), .trim_val(trim_val), .trim_next(trim_next)
  );

  trim_seg_decoder #(.TW(TW), .TRIM_MAX(TRIM_MAX), .TRIM_RST(TRIM_RST)) u_dec (
    .clk(clk), .rst(rst), .trim_next(trim_next), .seg_word(seg_word)
  );

  p_seg_match_r11: assert property (@(posedge clk) disable iff (rst)
    $countones(seg_word) == int'(trim_val));

  p_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !trim_gnt);

  p_lock_holds_r4: assert property (@(posedge clk) disable iff (rst)
    ph_lock |=> $stable(trim_val));
endmodule

// File: tb/tb_supply_trim_ctrl.sv
module tb_supply_trim_ctrl;
  logic        clk = 1'b0;
  logic        rst, en, ph_up, ph_dn, ph_lock, slow_req;
  logic [4:0]  trim_val;
  logic        trim_gnt, slow_gnt;
  logic [23:0] seg_word;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  supply_trim_ctrl dut (
    .clk(clk), .rst(rst), .en(en), .ph_up(ph_up), .ph_dn(ph_dn),
    .ph_lock(ph_lock), .slow_req(slow_req), .trim_val(trim_val),
    .trim_gnt(trim_gnt), .slow_gnt(slow_gnt), .seg_word(seg_word)
  );

  // {up, dn, lock, req, en} -> expected {trim, trim_gnt, slow_gnt} after the edge
  localparam int NV = 21;
  localparam logic [11:0] VEC [NV] = '{
    {5'b10001, 5'd13, 2'b10},  // R2 raise
    {5'b10001, 5'd13, 2'b00},  // R5 settling
    {5'b10001, 5'd13, 2'b00},
    {5'b10001, 5'd13, 2'b00},
    {5'b10001, 5'd14, 2'b10},  // R5 exact 4-edge spacing
    {5'b00001, 5'd14, 2'b00},  // R4 no indication
    {5'b00001, 5'd14, 2'b00},
    {5'b00001, 5'd14, 2'b00},
    {5'b01001, 5'd13, 2'b10},  // R3 lower
    {5'b00101, 5'd13, 2'b00},  // R4 lock
    {5'b00101, 5'd13, 2'b00},
    {5'b00101, 5'd13, 2'b00},
    {5'b11001, 5'd13, 2'b00},  // R4 up and dn together
    {5'b00101, 5'd13, 2'b00},  // R4 lock
    {5'b10101, 5'd13, 2'b00},  // R4 lock beats up
    {5'b10000, 5'd13, 2'b00},  // R7 disabled
    {5'b10011, 5'd13, 2'b01},  // R8 slow wins, R10
    {5'b10001, 5'd13, 2'b00},  // R9 settle after grant
    {5'b10001, 5'd13, 2'b00},
    {5'b10001, 5'd13, 2'b00},
    {5'b10001, 5'd14, 2'b10}   // R9 first step allowed
  };

  function automatic logic [23:0] therm(input int v);
    logic [23:0] w = '0;
    for (int i = 0; i < 24; i++) if (i < v) w[i] = 1'b1;
    return w;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_all(input string req, input int t, input int tg, input int sg);
    chk(req, int'(trim_val), t);
    chk(req, int'(trim_gnt), tg);
    chk(req, int'(slow_gnt), sg);
    n_run++;
    if (seg_word !== therm(t)) begin
      n_fail++;
      $display("FAIL R11 (%s): seg_word got %h expected %h", req, seg_word, therm(t));
    end
  endtask

  task automatic cycle(input logic [4:0] ctl);
    @(negedge clk);
    {ph_up, ph_dn, ph_lock, slow_req, en} = ctl;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {ph_up, ph_dn, ph_lock, slow_req, en} = 5'b00001;
    repeat (2) @(posedge clk);
    #1;
    check_all("R1 during reset", 12, 0, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    rst = 1'b1;
    {ph_up, ph_dn, ph_lock, slow_req, en} = 5'b00000;
    do_reset();
    cycle(5'b00001);
    check_all("R1 after release", 12, 0, 0);

    do_reset();
    for (int k = 0; k < NV; k++) begin
      cycle(VEC[k][11:7]);
      check_all($sformatf("vector %0d", k), int'(VEC[k][6:2]),
                int'(VEC[k][1]), int'(VEC[k][0]));
    end

    // R6 upper bound
    do_reset();
    for (int k = 0; k < 60; k++) cycle(5'b10001);
    check_all("R6 saturate high", 24, 0, 0);
    for (int k = 0; k < 8; k++) begin
      cycle(5'b10001);
      check_all("R6 no grant at top", 24, 0, 0);
    end

    // R6 lower bound
    for (int k = 0; k < 110; k++) cycle(5'b01001);
    check_all("R6 saturate low", 0, 0, 0);
    for (int k = 0; k < 8; k++) begin
      cycle(5'b01001);
      check_all("R6 no grant at bottom", 0, 0, 0);
    end

    // R8 held request: grant every sampled cycle, trim frozen
    do_reset();
    cycle(5'b10011);
    check_all("R8 held req 1", 12, 0, 1);
    cycle(5'b10011);
    check_all("R8 held req 2", 12, 0, 1);
    cycle(5'b10001);
    check_all("R9 hold after req", 12, 0, 0);

    done = 1'b1;
    report();
  end
endmodule